// File: doc/BRIEF.md
# Patched Frame-of-Reference Block Decoder

This block expands one block of frame-of-reference compressed integers into full-width values. Software or an upstream engine fills two local stores: one holds the narrow codes and the other holds the wide exception values. It then pulses a start strobe together with a header. The header gives the base value, the position of the first exception hole, the element count, the number of stored exceptions and a delta-mode flag.

Decoding runs in two passes over an internal output buffer. The first pass writes base plus code at every position and does not test for exceptions. The second pass visits only the holes. The code stored in each hole is the distance to the next hole, so the pass follows these links and overwrites each hole with an exception value. The exception values are consumed from the end of the exception store backwards. In delta mode, a third pass turns the patched values into a running sum. When done is high, the results are read through a combinational read port.

Top module: `pfor_decoder`

## Requirements
- R1: After reset, busy_o and done_o are both low.
- R2: A start_i seen while the block is not busy latches the header, and busy_o (or done_o, for a zero count) is high one cycle later. A start_i seen while busy_o is high is ignored, and the block's result is unchanged.
- R3: Pass one writes base + code to every position 0..count-1, with the code zero-extended and the sum taken modulo 2^32. Hole positions are also written in this pass.
- R4: The patch walk begins at the header's first-hole position. Each next position is the current position plus the code stored there plus one. The walk ends once the position is greater than or equal to count.
- R5: The first hole visited receives exception entry exc_num-1, the next hole receives exc_num-2, and so on downward.
- R6: When the first-hole position is greater than or equal to count, no position is patched, and every output equals base + code.
- R7: With delta mode set, output i equals the modulo 2^32 sum of the patched values at positions 0..i. The sum is formed after patching, so exception values take part as deltas.
- R8: done_o rises when busy_o falls. It stays high until the next accepted start. busy_o and done_o are never high together.
- R9: A count of zero finishes with done_o high on the cycle after the start and with no buffer writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_we_i | input | 1 | Code store write enable |
| code_waddr_i | input | AW | Code store write address |
| code_wdata_i | input | CODE_W | Code written |
| exc_we_i | input | 1 | Exception store write enable |
| exc_waddr_i | input | EW | Exception store write address |
| exc_wdata_i | input | DATA_W | Exception value written |
| start_i | input | 1 | Start strobe; header sampled with it |
| base_i | input | DATA_W | Block base value |
| first_i | input | CW | Position of the first hole |
| count_i | input | CW | Element count, 0..MAX_N |
| exc_num_i | input | ECW | Number of exceptions stored |
| delta_i | input | 1 | Running-sum mode |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | Results valid in the buffer |
| rd_addr_i | input | AW | Output buffer read address |
| rd_data_o | output | DATA_W | Output buffer read data |

## Verification
The hardest condition to reach is a full-length block whose hole chain uses the largest link a code can hold. The same block must also end on a hole in the last position with a zero link, and it must run in delta mode. Only a walk shaped that way checks the exit compare at its exact boundary, the downward exception order over many holes, and the accumulation that runs after patching, all in one run. The stimulus builds this case from a list of hole positions. It computes each hole's link code from the gap to the next hole, loads exception values that are each distinct, and compares every output against a two-pass model kept in the bench.

// File: rtl/pfor_pkg.sv
package pfor_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_PATCH,
    ST_DELTA,
    ST_DONE
  } dec_state_e;
endpackage

// File: rtl/pfor_regfile.sv
module pfor_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int NRD   = 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][W-1:0]   rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end
endmodule

// File: rtl/pfor_ctrl.sv
module pfor_ctrl
  import pfor_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int DATA_W  = 32,
  parameter int MAX_N   = 64,
  parameter int MAX_EXC = 16,
  localparam int AW  = $clog2(MAX_N),
  localparam int CW  = $clog2(MAX_N + 1),
  localparam int EW  = $clog2(MAX_EXC),
  localparam int ECW = $clog2(MAX_EXC + 1),
  localparam int NW  = CW + CODE_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [CW-1:0]     first_i,
  input  logic [CW-1:0]     count_i,
  input  logic [ECW-1:0]    exc_num_i,
  input  logic              delta_i,
  output logic [AW-1:0]     code_raddr_o,
  input  logic [CODE_W-1:0] code_rdata_i,
  output logic [EW-1:0]     exc_raddr_o,
  input  logic [DATA_W-1:0] exc_rdata_i,
  output logic              out_we_o,
  output logic [AW-1:0]     out_waddr_o,
  output logic [DATA_W-1:0] out_wdata_o,
  output logic [AW-1:0]     out_raddr_o,
  input  logic [DATA_W-1:0] out_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              in_patch_o,
  output logic [CW-1:0]     cur_o,
  output logic [ECW-1:0]    exc_ptr_o,
  output logic [CW-1:0]     count_o
);
  dec_state_e st_q, st_d;
  logic [CW-1:0]     idx_q, idx_d;
  logic [CW-1:0]     cur_q, cur_d;
  logic [ECW-1:0]    exc_q, exc_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CW-1:0]     first_q, first_d;
  logic [DATA_W-1:0] base_q, base_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              delta_q, delta_d;

  logic [NW-1:0]     nxt;
  logic              last_idx;
  logic [DATA_W-1:0] code_ext;
  logic [DATA_W-1:0] sum;
  logic [ECW-1:0]    exc_m1;
  logic              accept;

  assign code_ext = {{(DATA_W-CODE_W){1'b0}}, code_rdata_i};
  assign nxt      = {{(NW-CW){1'b0}}, cur_q} + {{(NW-CODE_W){1'b0}}, code_rdata_i} + NW'(1);
  assign last_idx = (idx_q == cnt_q - CW'(1));
  assign sum      = acc_q + out_rdata_i;
  assign exc_m1   = exc_q - ECW'(1);
  assign accept   = start_i && (st_q == ST_IDLE || st_q == ST_DONE);

  assign code_raddr_o = (st_q == ST_PATCH) ? cur_q[AW-1:0] : idx_q[AW-1:0];
  assign exc_raddr_o  = exc_m1[EW-1:0];
  assign out_raddr_o  = idx_q[AW-1:0];

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    cur_d       = cur_q;
    exc_d       = exc_q;
    cnt_d       = cnt_q;
    first_d     = first_q;
    base_d      = base_q;
    acc_d       = acc_q;
    delta_d     = delta_q;
    out_we_o    = 1'b0;
    out_waddr_o = idx_q[AW-1:0];
    out_wdata_o = base_q + code_ext;

    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          cnt_d   = count_i;
          first_d = first_i;
          base_d  = base_i;
          exc_d   = exc_num_i;
          delta_d = delta_i;
          idx_d   = '0;
          acc_d   = '0;
          st_d    = (count_i == '0) ? ST_DONE : ST_DECODE;
        end
      end
      ST_DECODE: begin
        out_we_o = 1'b1;
        if (last_idx) begin
          idx_d = '0;
          if (first_q < cnt_q) begin
            cur_d = first_q;
            st_d  = ST_PATCH;
          end else begin
            st_d = delta_q ? ST_DELTA : ST_DONE;
          end
        end else begin
          idx_d = idx_q + CW'(1);
        end
      end
      ST_PATCH: begin
        out_we_o    = 1'b1;
        out_waddr_o = cur_q[AW-1:0];
        out_wdata_o = exc_rdata_i;
        exc_d       = exc_m1;
        if (nxt >= {{(NW-CW){1'b0}}, cnt_q}) begin
          st_d = delta_q ? ST_DELTA : ST_DONE;
        end else begin
          cur_d = nxt[CW-1:0];
        end
      end
      ST_DELTA: begin
        out_we_o    = 1'b1;
        out_wdata_o = sum;
        acc_d       = sum;
        if (last_idx) st_d = ST_DONE;
        else          idx_d = idx_q + CW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      exc_q   <= '0;
      cnt_q   <= '0;
      first_q <= '0;
      base_q  <= '0;
      acc_q   <= '0;
      delta_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      cur_q   <= cur_d;
      exc_q   <= exc_d;
      cnt_q   <= cnt_d;
      first_q <= first_d;
      base_q  <= base_d;
      acc_q   <= acc_d;
      delta_q <= delta_d;
    end
  end

  assign busy_o     = (st_q == ST_DECODE) || (st_q == ST_PATCH) || (st_q == ST_DELTA);
  assign done_o     = (st_q == ST_DONE);
  assign in_patch_o = (st_q == ST_PATCH);
  assign cur_o      = cur_q;
  assign exc_ptr_o  = exc_q;
  assign count_o    = cnt_q;
endmodule

// File: rtl/pfor_decoder.sv
module pfor_decoder #(
  parameter int CODE_W  = 3,
  parameter int DATA_W  = 32,
  parameter int MAX_N   = 64,
  parameter int MAX_EXC = 16,
  localparam int AW  = $clog2(MAX_N),
  localparam int CW  = $clog2(MAX_N + 1),
  localparam int EW  = $clog2(MAX_EXC),
  localparam int ECW = $clog2(MAX_EXC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_we_i,
  input  logic [AW-1:0]     code_waddr_i,
  input  logic [CODE_W-1:0] code_wdata_i,
  input  logic              exc_we_i,
  input  logic [EW-1:0]     exc_waddr_i,
  input  logic [DATA_W-1:0] exc_wdata_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [CW-1:0]     first_i,
  input  logic [CW-1:0]     count_i,
  input  logic [ECW-1:0]    exc_num_i,
  input  logic              delta_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [AW-1:0]     code_raddr;
  logic [CODE_W-1:0] code_rdata;
  logic [EW-1:0]     exc_raddr;
  logic [DATA_W-1:0] exc_rdata;
  logic              out_we;
  logic [AW-1:0]     out_waddr;
  logic [DATA_W-1:0] out_wdata;
  logic [AW-1:0]     out_raddr;
  logic [1:0][AW-1:0]     out_ra;
  logic [1:0][DATA_W-1:0] out_rd;
  logic              in_patch;
  logic [CW-1:0]     cur;
  logic [ECW-1:0]    exc_ptr;
  logic [CW-1:0]     count_q;

  pfor_regfile #(.W(CODE_W), .DEPTH(MAX_N), .NRD(1)) u_code (
    .clk_i   (clk_i),
    .we_i    (code_we_i),
    .waddr_i (code_waddr_i),
    .wdata_i (code_wdata_i),
    .raddr_i (code_raddr),
    .rdata_o (code_rdata)
  );

  pfor_regfile #(.W(DATA_W), .DEPTH(MAX_EXC), .NRD(1)) u_exc (
    .clk_i   (clk_i),
    .we_i    (exc_we_i),
    .waddr_i (exc_waddr_i),
    .wdata_i (exc_wdata_i),
    .raddr_i (exc_raddr),
    .rdata_o (exc_rdata)
  );

  assign out_ra[0] = out_raddr;
  assign out_ra[1] = rd_addr_i;

  pfor_regfile #(.W(DATA_W), .DEPTH(MAX_N), .NRD(2)) u_out (
    .clk_i   (clk_i),
    .we_i    (out_we),
    .waddr_i (out_waddr),
    .wdata_i (out_wdata),
    .raddr_i (out_ra),
    .rdata_o (out_rd)
  );

  assign rd_data_o = out_rd[1];

  pfor_ctrl #(
    .CODE_W (CODE_W),
    .DATA_W (DATA_W),
    .MAX_N  (MAX_N),
    .MAX_EXC(MAX_EXC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .base_i       (base_i),
    .first_i      (first_i),
    .count_i      (count_i),
    .exc_num_i    (exc_num_i),
    .delta_i      (delta_i),
    .code_raddr_o (code_raddr),
    .code_rdata_i (code_rdata),
    .exc_raddr_o  (exc_raddr),
    .exc_rdata_i  (exc_rdata),
    .out_we_o     (out_we),
    .out_waddr_o  (out_waddr),
    .out_wdata_o  (out_wdata),
    .out_raddr_o  (out_raddr),
    .out_rdata_i  (out_rd[0]),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .in_patch_o   (in_patch),
    .cur_o        (cur),
    .exc_ptr_o    (exc_ptr),
    .count_o      (count_q)
  );
endmodule

// File: rtl/pfor_decoder_chk.sv
module pfor_decoder_chk #(
  parameter int AW  = 6,
  parameter int CW  = 7,
  parameter int ECW = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           out_we,
  input logic [AW-1:0]  out_waddr,
  input logic           in_patch,
  input logic [CW-1:0]  cur,
  input logic [ECW-1:0] exc_ptr,
  input logic [CW-1:0]  count_q
);
  p_busy_done_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_done_on_finish_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_start_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o || done_o));

  p_write_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we |-> ({1'b0, out_waddr} < (AW+1)'(count_q)));

  p_walk_forward_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_patch && $past(in_patch)) |-> (cur > $past(cur)));

  p_exc_descend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_patch && $past(in_patch)) |-> (exc_ptr == $past(exc_ptr) - ECW'(1)));

  p_idle_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_we);
endmodule

bind pfor_decoder pfor_decoder_chk #(.AW(AW), .CW(CW), .ECW(ECW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .out_we    (out_we),
  .out_waddr (out_waddr),
  .in_patch  (in_patch),
  .cur       (cur),
  .exc_ptr   (exc_ptr),
  .count_q   (count_q)
);

// File: tb/tb_pfor_decoder.sv
module tb_pfor_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W  = 3;
  localparam int DATA_W  = 32;
  localparam int MAX_N   = 64;
  localparam int MAX_EXC = 16;
  localparam int AW  = $clog2(MAX_N);
  localparam int CW  = $clog2(MAX_N + 1);
  localparam int EW  = $clog2(MAX_EXC);
  localparam int ECW = $clog2(MAX_EXC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic              code_we = 1'b0;
  logic [AW-1:0]     code_waddr = '0;
  logic [CODE_W-1:0] code_wdata = '0;
  logic              exc_we = 1'b0;
  logic [EW-1:0]     exc_waddr = '0;
  logic [DATA_W-1:0] exc_wdata = '0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] base = '0;
  logic [CW-1:0]     first = '0;
  logic [CW-1:0]     count = '0;
  logic [ECW-1:0]    exc_num = '0;
  logic              delta = 1'b0;
  logic              busy, done;
  logic [AW-1:0]     rd_addr = '0;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [CODE_W-1:0] codes [MAX_N];
  logic [DATA_W-1:0] excs  [MAX_EXC];
  logic [DATA_W-1:0] expv  [MAX_N];

  always #(CLK_PERIOD/2) clk = ~clk;

  pfor_decoder #(.CODE_W(CODE_W), .DATA_W(DATA_W), .MAX_N(MAX_N), .MAX_EXC(MAX_EXC)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .code_we_i(code_we), .code_waddr_i(code_waddr), .code_wdata_i(code_wdata),
    .exc_we_i(exc_we), .exc_waddr_i(exc_waddr), .exc_wdata_i(exc_wdata),
    .start_i(start), .base_i(base), .first_i(first), .count_i(count),
    .exc_num_i(exc_num), .delta_i(delta), .busy_o(busy), .done_o(done),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int n, input int ne);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); code_we = 1'b1; code_waddr = AW'(i); code_wdata = codes[i];
    end
    for (int k = 0; k < ne; k++) begin
      @(negedge clk); code_we = 1'b0; exc_we = 1'b1; exc_waddr = EW'(k); exc_wdata = excs[k];
    end
    @(negedge clk); code_we = 1'b0; exc_we = 1'b0;
  endtask

  // two-pass reference built from R3..R7
  task automatic model(input int n, input logic [DATA_W-1:0] b, input int f, input int ne, input bit dm);
    int cur; int j; logic [DATA_W-1:0] acc;
    for (int i = 0; i < n; i++) expv[i] = b + DATA_W'(codes[i]);
    cur = f; j = ne;
    while (cur < n) begin
      j--; expv[cur] = excs[j];
      cur = cur + int'(codes[cur]) + 1;
    end
    if (dm) begin
      acc = '0;
      for (int i = 0; i < n; i++) begin acc = acc + expv[i]; expv[i] = acc; end
    end
  endtask

  task automatic pulse_start(input int n, input logic [DATA_W-1:0] b, input int f, input int ne, input bit dm);
    @(negedge clk);
    start = 1'b1; base = b; first = CW'(f); count = CW'(n); exc_num = ECW'(ne); delta = dm;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    check(req, 32'(done), 32'd1);
  endtask

  task automatic compare(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      rd_addr = AW'(i); #1;
      check(req, rd_data, expv[i]);
    end
  endtask

  task automatic run(input string req, input int n, input logic [DATA_W-1:0] b, input int f, input int ne, input bit dm);
    load(n, ne);
    model(n, b, f, ne, dm);
    pulse_start(n, b, f, ne, dm);
    wait_done(req);
    compare(req, n);
  endtask

  task automatic t_reset;
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
  endtask

  task automatic t_plain; // R3 R6: first >= n, no patching
    for (int i = 0; i < 8; i++) codes[i] = CODE_W'(7 - i);
    run("R6", 8, 32'd100, 8, 0, 1'b0);
    rd_addr = AW'(0); #1; check("R3 pos0", rd_data, 32'd107);
  endtask

  task automatic t_holes; // R4 R5
    logic [CODE_W-1:0] c [10] = '{3'd3, 3'd1, 3'd2, 3'd1, 3'd5, 3'd1, 3'd2, 3'd2, 3'd5, 3'd3};
    for (int i = 0; i < 10; i++) codes[i] = c[i];
    excs[0] = 32'd14; excs[1] = 32'd13; excs[2] = 32'd12;
    run("R4", 10, 32'd0, 2, 3, 1'b0);
    rd_addr = AW'(2); #1; check("R5 first hole gets last entry", rd_data, 32'd12);
    rd_addr = AW'(7); #1; check("R5 last hole gets entry 0", rd_data, 32'd14);
    rd_addr = AW'(6); #1; check("R3 regular", rd_data, 32'd2);
  endtask

  task automatic t_edges; // R4 hole at 0 and at n-1
    for (int i = 0; i < 6; i++) codes[i] = CODE_W'(i + 1);
    codes[0] = 3'd4; codes[5] = 3'd0;
    excs[0] = 32'hAAAA; excs[1] = 32'hBBBB;
    run("R4 edges", 6, 32'd10, 0, 2, 1'b0);
    rd_addr = AW'(5); #1; check("R4 tail hole", rd_data, 32'hAAAA);
  endtask

  task automatic t_wrap; // R3 modulo
    for (int i = 0; i < 4; i++) codes[i] = CODE_W'(i);
    run("R3 wrap", 4, 32'hFFFF_FFFE, 4, 0, 1'b0);
    rd_addr = AW'(3); #1; check("R3 wrap literal", rd_data, 32'd1);
  endtask

  task automatic t_delta; // R7
    logic [DATA_W-1:0] e [5] = '{32'd3, 32'd5, 32'd10, 32'd60, 32'd64};
    codes[0] = 3'd1; codes[1] = 3'd0; codes[2] = 3'd3; codes[3] = 3'd1; codes[4] = 3'd2;
    excs[0] = 32'd50;
    run("R7", 5, 32'd2, 3, 1, 1'b1);
    for (int i = 0; i < 5; i++) begin
      rd_addr = AW'(i); #1; check("R7 literal", rd_data, e[i]);
    end
  endtask

  task automatic t_handshake; // R2 R8
    for (int i = 0; i < 10; i++) codes[i] = CODE_W'(i % 8);
    load(10, 0);
    model(10, 32'd5, 10, 0, 1'b0);
    pulse_start(10, 32'd5, 10, 0, 1'b0);
    check("R2 busy after start", 32'(busy), 32'd1);
    check("R8 not done while busy", 32'(done), 32'd0);
    // start while busy must be ignored
    pulse_start(3, 32'd900, 3, 0, 1'b1);
    wait_done("R8 done");
    compare("R2 ignored start", 10);
    repeat (5) @(negedge clk);
    check("R8 done held", 32'(done), 32'd1);
    check("R8 busy low", 32'(busy), 32'd0);
    pulse_start(10, 32'd5, 10, 0, 1'b0);
    check("R8 done cleared", 32'(done), 32'd0);
    wait_done("R8 rerun");
  endtask

  task automatic t_empty; // R9
    @(negedge clk);
    rd_addr = '0; #1;
    pulse_start(0, 32'd77, 0, 0, 1'b0);
    check("R9 done", 32'(done), 32'd1);
    check("R9 busy", 32'(busy), 32'd0);
    rd_addr = '0; #1;
    check("R9 buffer untouched", rd_data, 32'd5 + 32'd0);
  endtask

  task automatic t_full; // R4 R5 R7 full length, max links
    int holes [9] = '{3, 10, 18, 26, 33, 41, 49, 57, 63};
    for (int i = 0; i < MAX_N; i++) codes[i] = CODE_W'((i * 5 + 3) % 8);
    for (int h = 0; h < 9; h++)
      codes[holes[h]] = (h == 8) ? CODE_W'(0) : CODE_W'(holes[h+1] - holes[h] - 1);
    for (int k = 0; k < 9; k++) excs[k] = 32'd1000 + 32'(k * 7);
    run("R7 full", MAX_N, 32'd3, 3, 9, 1'b1);
    run("R5 full", MAX_N, 32'd3, 3, 9, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_holes();
    t_edges();
    t_wrap();
    t_delta();
    t_handshake();
    t_empty();
    t_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule